// File: doc/BRIEF.md
# Receiver Power Mode Supervisor

This block is the digital supervisor of a wireless power receiver. It turns two mode-select pins and a flag for adapter voltage above threshold into two controls. One switches the gate of an external adapter switch. The other allows wireless delivery. It holds the output regulator and the status output off until the rectifier has reached its no-load target. It also picks the rectifier voltage target from a quantised load-current code.

The block schedules control-error packet requests. They come at a slow steady-state rate and at a faster rate while a large load transient is flagged. When a fault, a termination condition or a convergence timeout is present, the block raises an end-power request and gives a reason code. Comparators, converters and the packet modulator sit outside the block and only exchange digital flags and codes with it.

Top module: `pms_top`

## Requirements
- R1: With ctl_a=0 and ctl_b=0, one clock edge after the inputs are sampled, adapter_live=1 gives adapter_gate_on=1 and wireless_on=0, and adapter_live=0 gives adapter_gate_on=0 and wireless_on=1.
- R2: With ctl_a=0 and ctl_b=1, adapter_gate_on=0 and wireless_on=1 whatever the value of adapter_live, and adapter_live raises no end-power request.
- R3: With ctl_a=1 and ctl_b=0, adapter_gate_on=1 and wireless_on=0 whatever the value of adapter_live.
- R4: With ctl_a=1 and ctl_b=1, adapter_gate_on=0, wireless_on=0 and ldo_on=0.
- R5: rect_target encodes 0=7.08 V, 1=6.28 V, 2=5.53 V, 3=5.11 V. The target steps up past a boundary (20, 40, 80 load codes at 5 mA per code) when load_code is greater than or equal to that boundary.
- R6: The target steps back down past a boundary only when load_code is below the boundary minus 8 codes (40 mA).
- R7: rect_target moves by at most one step per clock, so a large load jump walks through the intermediate targets on consecutive edges.
- R8: While wireless_on=1, no end-power request is present and load_transient=0, ce_pkt_req pulses for one clock every SLOW_MS milliseconds (500 clocks in the bench).
- R9: While load_transient=1 the pulse period is FAST_MS milliseconds (64 clocks in the bench). The interval timer restarts on the edge that first samples load_transient high, so the first fast pulse comes exactly FAST period edges later.
- R10: ldo_on and status_on are equal. Both stay 0 after wireless_on rises until rect_converged has been sampled high while wireless_on=1, and they turn on one edge after that.
- R11: ept_req=1 with ept_code 0x02 one edge after tj_over or ilim_short is high. The code is 0x03 for temp_window_fault, 0x01 when ctl_a=1, and 0x00 when the adapter is present in the ctl_a=0/ctl_b=0 mode.
- R12: When several causes are present, the code follows the priority 0x02, then 0x03, then 0x01, then 0x00, then 0x08.
- R13: If rect_converged has not been seen after CONV_MS milliseconds of wireless_on=1 (100 clocks in the bench), ept_req rises with code 0x08 on the next edge. This request persists until wireless_on falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_a | input | 1 | Mode select pin A (forces the adapter gate) |
| ctl_b | input | 1 | Mode select pin B (blocks the adapter path) |
| adapter_live | input | 1 | Adapter voltage above threshold |
| load_code | input | LOAD_W | Quantised load current, 5 mA per code |
| rect_converged | input | 1 | Rectifier reached its no-load target |
| load_transient | input | 1 | Large transient flagged |
| tj_over | input | 1 | Junction over-temperature |
| ilim_short | input | 1 | Limit resistor detected as shorted |
| temp_window_fault | input | 1 | External temperature outside its window |
| adapter_gate_on | output | 1 | Enable for the external adapter switch gate |
| wireless_on | output | 1 | Wireless delivery allowed |
| ldo_on | output | 1 | Output regulator enable |
| status_on | output | 1 | Status output active |
| rect_target | output | 2 | Rectifier voltage target code |
| ce_pkt_req | output | 1 | One-clock control-error packet request |
| ept_req | output | 1 | End-power request |
| ept_code | output | 8 | End-power reason code |

## Verification
The hardest state to reach from the ports is the restart of the packet timer in the middle of a slow interval. The bench first locks onto a slow pulse and then waits 200 clocks. Only then does it raise the transient flag, so a timer that keeps counting would give a gap near 300 clocks where 64 are expected. The no-response timeout also needs care. The bench drops the mode to all-off to clear the latched convergence, then re-enters wireless mode with convergence held low. It checks both the cycle just before the request and the cycle it appears. The hysteresis band is tested at both sides of each falling threshold (72/71 and 32/31).

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [1:0] {
        PATH_ADAPTER_FIRST = 2'b00,
        PATH_WIRELESS_ONLY = 2'b01,
        PATH_GATE_FORCED   = 2'b10,
        PATH_ALL_OFF       = 2'b11
    } path_mode_e;

    typedef enum logic [1:0] {
        TGT_7V08 = 2'd0,
        TGT_6V28 = 2'd1,
        TGT_5V53 = 2'd2,
        TGT_5V11 = 2'd3
    } rect_tgt_e;

    localparam int NUM_EDGES = 3;

    localparam logic [7:0] EPT_UNKNOWN   = 8'h00;
    localparam logic [7:0] EPT_CHG_DONE  = 8'h01;
    localparam logic [7:0] EPT_INT_FAULT = 8'h02;
    localparam logic [7:0] EPT_OVER_TEMP = 8'h03;
    localparam logic [7:0] EPT_NO_RESP   = 8'h08;

    typedef struct packed {
        logic adapter_gate;
        logic wireless;
    } path_ctl_t;

    typedef struct packed {
        logic int_fault;
        logic over_temp;
        logic chg_done;
        logic adapter_seen;
        logic no_resp;
    } ept_cause_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] code;
    } ept_msg_t;

    function automatic path_ctl_t decode_path(path_mode_e m, logic adp);
        path_ctl_t r;
        case (m)
            PATH_ADAPTER_FIRST: begin
                r.adapter_gate = adp;
                r.wireless     = ~adp;
            end
            PATH_WIRELESS_ONLY: begin
                r.adapter_gate = 1'b0;
                r.wireless     = 1'b1;
            end
            PATH_GATE_FORCED: begin
                r.adapter_gate = 1'b1;
                r.wireless     = 1'b0;
            end
            default: begin
                r.adapter_gate = 1'b0;
                r.wireless     = 1'b0;
            end
        endcase
        return r;
    endfunction

    function automatic ept_msg_t pick_ept(ept_cause_t c);
        ept_msg_t m;
        m.valid = 1'b1;
        if (c.int_fault)         m.code = EPT_INT_FAULT;
        else if (c.over_temp)    m.code = EPT_OVER_TEMP;
        else if (c.chg_done)     m.code = EPT_CHG_DONE;
        else if (c.adapter_seen) m.code = EPT_UNKNOWN;
        else if (c.no_resp)      m.code = EPT_NO_RESP;
        else begin
            m.valid = 1'b0;
            m.code  = EPT_UNKNOWN;
        end
        return m;
    endfunction

endpackage

// File: rtl/pms_path_decoder.sv
module pms_path_decoder
    import pms_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_a,
    input  logic       ctl_b,
    input  logic       adapter_live,
    output path_ctl_t  path_q,
    output path_mode_e mode_q,
    output logic       adapter_q
);

    path_mode_e mode_d;
    assign mode_d = path_mode_e'({ctl_a, ctl_b});

    always_ff @(posedge clk) begin
        if (rst) begin
            path_q    <= '0;
            mode_q    <= PATH_ADAPTER_FIRST;
            adapter_q <= 1'b0;
        end else begin
            path_q    <= decode_path(mode_d, adapter_live);
            mode_q    <= mode_d;
            adapter_q <= adapter_live;
        end
    end

endmodule

// File: rtl/pms_target_sel.sv
module pms_target_sel
    import pms_pkg::*;
#(
    parameter int LOAD_W     = 8,
    parameter int EDGE_A     = 20,
    parameter int EDGE_B     = 40,
    parameter int EDGE_C     = 80,
    parameter int HYST_CODES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LOAD_W-1:0] load_code,
    output rect_tgt_e         target
);

    localparam int EDGE [NUM_EDGES] = '{EDGE_A, EDGE_B, EDGE_C};

    int load_i;
    assign load_i = int'(32'(load_code));

    logic [NUM_EDGES-1:0] above_q;
    logic [1:0]           level;

    always_comb begin
        level = '0;
        for (int k = 0; k < NUM_EDGES; k++) begin
            level = level + 2'(above_q[k]);
        end
    end

    for (genvar i = 0; i < NUM_EDGES; i++) begin : g_edge
        logic rise_ok;
        logic fall_ok;
        assign rise_ok = (level == 2'(i))     && (load_i >= EDGE[i]);
        assign fall_ok = (level == 2'(i + 1)) && (load_i < (EDGE[i] - HYST_CODES));

        always_ff @(posedge clk) begin
            if (rst) begin
                above_q[i] <= 1'b0;
            end else if (!above_q[i] && rise_ok) begin
                above_q[i] <= 1'b1;
            end else if (above_q[i] && fall_ok) begin
                above_q[i] <= 1'b0;
            end
        end
    end

    assign target = rect_tgt_e'(level);

endmodule

// File: rtl/pms_pkt_sched.sv
module pms_pkt_sched #(
    parameter int SLOW_LIM = 500,
    parameter int FAST_LIM = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic transient,
    output logic req
);

    localparam int CNT_W = $clog2(SLOW_LIM + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             trans_q;
    logic             trans_rise;

    assign trans_rise = transient & ~trans_q;
    assign last       = transient ? CNT_W'(FAST_LIM - 1) : CNT_W'(SLOW_LIM - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            req     <= 1'b0;
            trans_q <= 1'b0;
        end else begin
            trans_q <= transient;
            req     <= 1'b0;
            if (!active || trans_rise) begin
                cnt <= '0;
            end else if (cnt >= last) begin
                cnt <= '0;
                req <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pms_ept_arbiter.sv
module pms_ept_arbiter
    import pms_pkg::*;
#(
    parameter int CONV_LIM = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wireless_q,
    input  path_mode_e mode_q,
    input  logic       adapter_q,
    input  logic       conv_in,
    input  logic       tj_over,
    input  logic       ilim_short,
    input  logic       temp_fault,
    output logic       conv_seen,
    output ept_msg_t   msg
);

    localparam int CW = $clog2(CONV_LIM + 1);

    logic          int_fault_q;
    logic          over_temp_q;
    logic          no_resp_q;
    logic [CW-1:0] wait_cnt;
    ept_cause_t    cause;

    always_ff @(posedge clk) begin
        if (rst) begin
            int_fault_q <= 1'b0;
            over_temp_q <= 1'b0;
        end else begin
            int_fault_q <= tj_over | ilim_short;
            over_temp_q <= temp_fault;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !wireless_q) begin
            conv_seen <= 1'b0;
            no_resp_q <= 1'b0;
            wait_cnt  <= '0;
        end else begin
            if (conv_in) begin
                conv_seen <= 1'b1;
            end
            if (conv_seen) begin
                wait_cnt <= '0;
            end else if (!no_resp_q) begin
                if (wait_cnt == CW'(CONV_LIM - 1)) begin
                    no_resp_q <= 1'b1;
                end else begin
                    wait_cnt <= wait_cnt + 1'b1;
                end
            end
        end
    end

    always_comb begin
        cause.int_fault    = int_fault_q;
        cause.over_temp    = over_temp_q;
        cause.chg_done     = (mode_q == PATH_GATE_FORCED) || (mode_q == PATH_ALL_OFF);
        cause.adapter_seen = (mode_q == PATH_ADAPTER_FIRST) && adapter_q;
        cause.no_resp      = no_resp_q;
        msg                = pick_ept(cause);
    end

endmodule

// File: rtl/pms_top.sv
module pms_top
    import pms_pkg::*;
#(
    parameter int LOAD_W     = 8,
    parameter int EDGE_A     = 20,
    parameter int EDGE_B     = 40,
    parameter int EDGE_C     = 80,
    parameter int HYST_CODES = 8,
    parameter int CLK_PER_MS = 1000,
    parameter int SLOW_MS    = 250,
    parameter int FAST_MS    = 32,
    parameter int CONV_MS    = 500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_a,
    input  logic              ctl_b,
    input  logic              adapter_live,
    input  logic [LOAD_W-1:0] load_code,
    input  logic              rect_converged,
    input  logic              load_transient,
    input  logic              tj_over,
    input  logic              ilim_short,
    input  logic              temp_window_fault,
    output logic              adapter_gate_on,
    output logic              wireless_on,
    output logic              ldo_on,
    output logic              status_on,
    output logic [1:0]        rect_target,
    output logic              ce_pkt_req,
    output logic              ept_req,
    output logic [7:0]        ept_code
);

    localparam int SLOW_LIM = CLK_PER_MS * SLOW_MS;
    localparam int FAST_LIM = CLK_PER_MS * FAST_MS;
    localparam int CONV_LIM = CLK_PER_MS * CONV_MS;

    path_ctl_t  path_q;
    path_mode_e mode_q;
    logic       adapter_q;
    logic       conv_seen;
    ept_msg_t   msg;
    rect_tgt_e  tgt;
    logic       deliver;

    pms_path_decoder u_path (
        .clk          (clk),
        .rst          (rst),
        .ctl_a        (ctl_a),
        .ctl_b        (ctl_b),
        .adapter_live (adapter_live),
        .path_q       (path_q),
        .mode_q       (mode_q),
        .adapter_q    (adapter_q)
    );

    pms_target_sel #(
        .LOAD_W     (LOAD_W),
        .EDGE_A     (EDGE_A),
        .EDGE_B     (EDGE_B),
        .EDGE_C     (EDGE_C),
        .HYST_CODES (HYST_CODES)
    ) u_tgt (
        .clk       (clk),
        .rst       (rst),
        .load_code (load_code),
        .target    (tgt)
    );

    pms_ept_arbiter #(
        .CONV_LIM (CONV_LIM)
    ) u_ept (
        .clk        (clk),
        .rst        (rst),
        .wireless_q (path_q.wireless),
        .mode_q     (mode_q),
        .adapter_q  (adapter_q),
        .conv_in    (rect_converged),
        .tj_over    (tj_over),
        .ilim_short (ilim_short),
        .temp_fault (temp_window_fault),
        .conv_seen  (conv_seen),
        .msg        (msg)
    );

    pms_pkt_sched #(
        .SLOW_LIM (SLOW_LIM),
        .FAST_LIM (FAST_LIM)
    ) u_pkt (
        .clk       (clk),
        .rst       (rst),
        .active    (path_q.wireless & ~msg.valid),
        .transient (load_transient),
        .req       (ce_pkt_req)
    );

    assign deliver         = path_q.wireless & conv_seen & ~msg.valid;
    assign adapter_gate_on = path_q.adapter_gate;
    assign wireless_on     = path_q.wireless;
    assign ldo_on          = deliver;
    assign status_on       = deliver;
    assign rect_target     = tgt;
    assign ept_req         = msg.valid;
    assign ept_code        = msg.code;

endmodule

// File: rtl/pms_chk.sv
module pms_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_a,
    input logic       ctl_b,
    input logic       load_transient,
    input logic       tj_over,
    input logic       ilim_short,
    input logic       adapter_gate_on,
    input logic       wireless_on,
    input logic       ldo_on,
    input logic       status_on,
    input logic [1:0] rect_target,
    input logic       ce_pkt_req,
    input logic       ept_req,
    input logic [7:0] ept_code
);

    a_r1_paths_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(adapter_gate_on && wireless_on));

    a_r2_adapter_blocked: assert property (@(posedge clk) disable iff (rst)
        $past(!ctl_a && ctl_b && !rst) |-> (!adapter_gate_on && wireless_on));

    a_r3_gate_forced: assert property (@(posedge clk) disable iff (rst)
        $past(ctl_a && !ctl_b && !rst) |-> (adapter_gate_on && !wireless_on));

    a_r4_all_off: assert property (@(posedge clk) disable iff (rst)
        $past(ctl_a && ctl_b && !rst) |-> (!adapter_gate_on && !wireless_on && !ldo_on));

    a_r7_single_step: assert property (@(posedge clk) disable iff (rst)
        ((int'(rect_target) - int'($past(rect_target))) <= 1) &&
        ((int'($past(rect_target)) - int'(rect_target)) <= 1));

    a_r8_one_clock_pulse: assert property (@(posedge clk) disable iff (rst)
        ce_pkt_req |=> !ce_pkt_req);

    a_r9_restart_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(load_transient) |=> !ce_pkt_req);

    a_r10_status_matches: assert property (@(posedge clk) disable iff (rst)
        status_on == ldo_on);

    a_r10_needs_wireless: assert property (@(posedge clk) disable iff (rst)
        ldo_on |-> (wireless_on && !ept_req));

    a_r11_internal_fault: assert property (@(posedge clk) disable iff (rst)
        $past((tj_over || ilim_short) && !rst) |-> (ept_req && ept_code == 8'h02));

endmodule

bind pms_top pms_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .ctl_a           (ctl_a),
    .ctl_b           (ctl_b),
    .load_transient  (load_transient),
    .tj_over         (tj_over),
    .ilim_short      (ilim_short),
    .adapter_gate_on (adapter_gate_on),
    .wireless_on     (wireless_on),
    .ldo_on          (ldo_on),
    .status_on       (status_on),
    .rect_target     (rect_target),
    .ce_pkt_req      (ce_pkt_req),
    .ept_req         (ept_req),
    .ept_code        (ept_code)
);

// File: tb/tb_pms_top.sv
`timescale 1ns/1ps
module tb_pms_top;

    localparam int SLOW = 500;
    localparam int FAST = 64;
    localparam int CONV = 100;

    localparam int F_GATE = 0, F_WL = 1, F_LDO = 2, F_STAT = 3,
                   F_TGT = 4, F_EPT = 5, F_CODE = 6, F_REQ = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_a = 1'b0, ctl_b = 1'b0, adapter_live = 1'b0;
    logic [7:0] load_code = 8'd0;
    logic       rect_converged = 1'b0, load_transient = 1'b0;
    logic       tj_over = 1'b0, ilim_short = 1'b0, temp_window_fault = 1'b0;
    logic       adapter_gate_on, wireless_on, ldo_on, status_on;
    logic [1:0] rect_target;
    logic       ce_pkt_req, ept_req;
    logic [7:0] ept_code;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    typedef struct {
        string rq;
        int    fld;
        int    exp_v;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    pms_top #(.CLK_PER_MS(2), .CONV_MS(50)) dut (
        .clk(clk), .rst(rst), .ctl_a(ctl_a), .ctl_b(ctl_b),
        .adapter_live(adapter_live), .load_code(load_code),
        .rect_converged(rect_converged), .load_transient(load_transient),
        .tj_over(tj_over), .ilim_short(ilim_short),
        .temp_window_fault(temp_window_fault),
        .adapter_gate_on(adapter_gate_on), .wireless_on(wireless_on),
        .ldo_on(ldo_on), .status_on(status_on), .rect_target(rect_target),
        .ce_pkt_req(ce_pkt_req), .ept_req(ept_req), .ept_code(ept_code)
    );

    function automatic int read_field(int f);
        case (f)
            F_GATE:  return int'(adapter_gate_on);
            F_WL:    return int'(wireless_on);
            F_LDO:   return int'(ldo_on);
            F_STAT:  return int'(status_on);
            F_TGT:   return int'(rect_target);
            F_EPT:   return int'(ept_req);
            F_CODE:  return int'(ept_code);
            default: return int'(ce_pkt_req);
        endcase
    endfunction

    task automatic chk(string rq, string what, int act, int exp_v);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, what, act, exp_v, $time);
        end
    endtask

    // monitor: pops expectations and compares away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            chk(it.rq, $sformatf("field%0d", it.fld), read_field(it.fld), it.exp_v);
        end
    end

    task automatic ex(string rq, int f, int v);
        item_t it;
        it.rq = rq; it.fld = f; it.exp_v = v;
        sb_q.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic sync_in();
        @(negedge clk);
    endtask

    task automatic gap(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ce_pkt_req && n < 3000);
    endtask

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1;
        ex("R1", F_GATE, 0); ex("R1", F_WL, 0); ex("R10", F_LDO, 0);
        ex("R5", F_TGT, 0); ex("R11", F_EPT, 0); ex("R8", F_REQ, 0);

        // R10 / R1: leave reset in adapter-first mode with no adapter
        sync_in(); rst = 1'b0; rect_converged = 1'b1;
        tick(); ex("R1", F_WL, 1); ex("R1", F_GATE, 0); ex("R10", F_LDO, 0); ex("R10", F_STAT, 0);
        tick(); ex("R10", F_LDO, 1); ex("R10", F_STAT, 1);

        // R1 adapter present
        sync_in(); adapter_live = 1'b1;
        tick(); ex("R1", F_GATE, 1); ex("R1", F_WL, 0); ex("R11", F_EPT, 1); ex("R11", F_CODE, 8'h00);

        // R2 adapter ignored
        sync_in(); ctl_b = 1'b1;
        tick(); ex("R2", F_GATE, 0); ex("R2", F_WL, 1); ex("R2", F_EPT, 0);
        sync_in(); adapter_live = 1'b0;
        tick(); ex("R2", F_GATE, 0); ex("R2", F_WL, 1);
        tick(); ex("R10", F_LDO, 1);

        // R8 slow interval, R9 restart and fast interval
        gap(n);
        gap(n); chk("R8", "slow gap", n, SLOW);
        repeat (200) @(negedge clk);
        load_transient = 1'b1;
        gap(n); chk("R9", "first fast gap", n, FAST + 1);
        gap(n); chk("R9", "fast gap", n, FAST);
        load_transient = 1'b0;
        gap(n); chk("R8", "back to slow", n, SLOW);

        // R5 / R6 / R7 target selection
        sync_in(); load_code = 8'd19;
        tick(); ex("R5", F_TGT, 0);
        sync_in(); load_code = 8'd20;
        tick(); ex("R5", F_TGT, 1);
        sync_in(); load_code = 8'd40;
        tick(); ex("R5", F_TGT, 2);
        sync_in(); load_code = 8'd80;
        tick(); ex("R5", F_TGT, 3);
        sync_in(); load_code = 8'd72;
        tick(); ex("R6", F_TGT, 3);
        sync_in(); load_code = 8'd71;
        tick(); ex("R6", F_TGT, 2);
        sync_in(); load_code = 8'd32;
        tick(); ex("R6", F_TGT, 2);
        sync_in(); load_code = 8'd31;
        tick(); ex("R6", F_TGT, 1);
        sync_in(); load_code = 8'd255;
        tick(); ex("R7", F_TGT, 2);
        tick(); ex("R7", F_TGT, 3);
        sync_in(); load_code = 8'd0;
        tick(); ex("R7", F_TGT, 2);
        tick(); ex("R7", F_TGT, 1);
        tick(); ex("R7", F_TGT, 0);

        // R11 limit resistor short, then recovery
        sync_in(); ilim_short = 1'b1;
        tick(); ex("R11", F_EPT, 1); ex("R11", F_CODE, 8'h02); ex("R10", F_LDO, 0);
        sync_in(); ilim_short = 1'b0;
        tick(); ex("R11", F_EPT, 0); ex("R10", F_LDO, 1);

        // R12 priority
        sync_in(); tj_over = 1'b1; temp_window_fault = 1'b1; ctl_a = 1'b1; ctl_b = 1'b0;
        tick(); ex("R12", F_CODE, 8'h02); ex("R3", F_GATE, 1); ex("R3", F_WL, 0);
        sync_in(); tj_over = 1'b0;
        tick(); ex("R12", F_CODE, 8'h03); ex("R12", F_EPT, 1);
        sync_in(); temp_window_fault = 1'b0;
        tick(); ex("R12", F_CODE, 8'h01); ex("R11", F_EPT, 1);
        sync_in(); adapter_live = 1'b1;
        tick(); ex("R3", F_GATE, 1); ex("R12", F_CODE, 8'h01);
        sync_in(); ctl_a = 1'b0;
        tick(); ex("R12", F_CODE, 8'h00); ex("R1", F_GATE, 1);
        sync_in(); adapter_live = 1'b0;
        tick(); ex("R12", F_EPT, 0);

        // R4 both paths off
        sync_in(); ctl_a = 1'b1; ctl_b = 1'b1; adapter_live = 1'b1;
        tick(); ex("R4", F_GATE, 0); ex("R4", F_WL, 0); ex("R4", F_LDO, 0);

        // R13 no-response timeout, R10 gating while unconverged
        sync_in(); ctl_a = 1'b0; ctl_b = 1'b1; rect_converged = 1'b0;
        tick(); ex("R13", F_WL, 1); ex("R13", F_EPT, 0); ex("R10", F_LDO, 0);
        repeat (CONV - 1) tick();
        ex("R13", F_EPT, 0); ex("R10", F_STAT, 0);
        tick(); ex("R13", F_EPT, 1); ex("R13", F_CODE, 8'h08);
        sync_in(); rect_converged = 1'b1;
        tick(); tick(); ex("R13", F_EPT, 1); ex("R10", F_LDO, 0);
        sync_in(); ctl_a = 1'b1;
        tick(); ex("R4", F_WL, 0);
        sync_in(); ctl_a = 1'b0;
        tick(); ex("R13", F_EPT, 0); ex("R10", F_LDO, 0);
        tick(); ex("R10", F_LDO, 1); ex("R10", F_STAT, 1);

        @(negedge clk); @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule